// File: doc/BRIEF.md
# Triggered Scan List Sequencer

This block walks a pointer through a short list of channel entries and, for each entry, waits out a programmable settling time before it announces that the channel is closed. Each entry holds a channel number and a valid flag. Software loads the list through an append port and controls the walk through two byte-wide registers: a control register and a settling-delay register. A step starts on a trigger pulse, or on a digital-bus trigger when that source is enabled. The settling time is 2^n microseconds, and a prescaler derived from the clock frequency produces the microsecond time base.

Several policies apply at the end of the list. In continuous mode the pointer wraps to the first entry and scanning goes on. Otherwise the list is exhausted, and an interrupt is raised if the final entry is valid. In immediate mode a single trigger runs all remaining entries back to back, with one settling period between them. A clear bit flushes the list and keeps it empty while it stays set. A pointer-reset strobe returns the walk to the first entry.

Top module: `scan_sequencer`

## Requirements
- R1: Register address 0 is the control register. Bit 0 is clear, bit 1 is digital-bus trigger enable, bit 2 is immediate mode, bit 3 is continuous mode and bit 4 is the pointer-reset strobe. Bits 7..5 are ignored on write. A read returns 1111 in bits 7..4 and the last written bits 3..0. The strobe does not read back.
- R2: Register address 1 holds the delay exponent n in bits 3..0, with bit 0 as the LSB. Upper written bits are ignored, and a read returns 1111 in bits 7..4 and n in bits 3..0.
- R3: Each append-port write stores {valid, channel} at the next list position, up to 16 entries. Appends made to a full list are ignored.
- R4: While the clear bit is 1, the list is flushed and held empty, appends are ignored and no step starts. After the bit returns to 0, the list stays empty until new entries are appended.
- R5: An accepted trigger in clock cycle c yields a one-cycle close_pulse carrying the current entry's channel exactly 1 + 2^n × (CLK_HZ/1e6) cycles later.
- R6: Triggers that arrive while a settling delay is running are ignored.
- R7: dbus_trig starts a step only while the digital-bus enable bit is 1. trig_in starts a step regardless of that bit.
- R8: With continuous mode off, the close of the last entry comes with a one-cycle scan_irq if and only if that entry's valid flag is 1. After that, triggers are ignored until the pointer is reset or the list is cleared.
- R9: With continuous mode on, the close of the last entry raises no interrupt, and the next trigger closes the first entry.
- R10: In immediate mode, one trigger closes the current entry and then each following entry up to the end of the list, one settling delay apart, with no further triggers.
- R11: Writing the control register with bit 4 set returns the pointer to the first entry and abandons any running delay, so no close occurs for that delay.
- R12: After reset, both registers read 8'hF0, the list is empty, and close_pulse and scan_irq are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 delay |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| list_we | input | 1 | Append one list entry |
| list_valid | input | 1 | Valid flag of the appended entry |
| list_chan | input | 4 | Channel number of the appended entry |
| trig_in | input | 1 | Trigger pulse |
| dbus_trig | input | 1 | Digital-bus trigger pulse |
| close_pulse | output | 1 | One-cycle channel-closed pulse |
| close_chan | output | 4 | Channel of the closed entry, valid with close_pulse |
| scan_irq | output | 1 | End-of-list interrupt pulse |

## Verification
On every cycle, the assertions check that a set clear bit empties the list and suppresses closes, that the pointer never passes the list length, that an interrupt only ever comes with a close, and that a running delay keeps its pointer until it fires or is cancelled. Only the bench's scenarios can show the exact settling cycle count for a given exponent, and that channels come out in order. The same applies to the end-of-list choice between wrap and interrupt, the immediate run-through, the gating of the bus trigger, and the cancellation by the pointer reset.

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int CLK_HZ = 100_000_000,
  parameter int DEPTH  = 16,
  parameter int CH_W   = 4,
  parameter int N_W    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic            reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            list_we,
  input  logic            list_valid,
  input  logic [CH_W-1:0] list_chan,
  input  logic            trig_in,
  input  logic            dbus_trig,
  output logic            close_pulse,
  output logic [CH_W-1:0] close_chan,
  output logic            scan_irq
);
  localparam int TICK_DIV = (CLK_HZ >= 1_000_000) ? CLK_HZ / 1_000_000 : 1;
  localparam int PW = $clog2(TICK_DIV + 1);
  localparam int IW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int CW = 1 << N_W;

  logic            clr_on, dbus_en, imm_en, cont_en;
  logic [N_W-1:0]  dly_n;
  logic [CH_W:0]   mem [DEPTH];
  logic [LW-1:0]   len, ptr;
  logic            busy;
  logic [PW-1:0]   presc;
  logic [CW-1:0]   cnt;

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata[7:5];

  wire ctrl_wr   = reg_we && !reg_addr;
  wire dly_wr    = reg_we && reg_addr;
  wire ptr_rst   = ctrl_wr && reg_wdata[4];
  wire tick      = busy && (presc == PW'(TICK_DIV - 1));
  wire fire      = tick && (cnt == CW'(1));
  wire has_entry = ptr < len;
  wire is_last   = (ptr + 1'b1) == len;
  wire [CH_W:0] cur = mem[ptr[IW-1:0]];
  wire trig_ok   = (trig_in || (dbus_en && dbus_trig)) && !busy && !clr_on && has_entry;
  wire chain     = fire && imm_en && !is_last;
  wire do_append = list_we && !clr_on && (len < LW'(DEPTH));

  assign reg_rdata = reg_addr ? {4'hF, 4'(dly_n)} : {4'hF, cont_en, imm_en, dbus_en, clr_on};

  always_ff @(posedge clk)
    if (do_append) mem[len[IW-1:0]] <= {list_valid, list_chan};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {clr_on, dbus_en, imm_en, cont_en} <= '0;
      dly_n       <= '0;
      len         <= '0;
      ptr         <= '0;
      busy        <= 1'b0;
      presc       <= '0;
      cnt         <= '0;
      close_pulse <= 1'b0;
      close_chan  <= '0;
      scan_irq    <= 1'b0;
    end else begin
      close_pulse <= 1'b0;
      scan_irq    <= 1'b0;
      if (ctrl_wr) {cont_en, imm_en, dbus_en, clr_on} <= reg_wdata[3:0];
      if (dly_wr)  dly_n <= reg_wdata[N_W-1:0];

      if (clr_on) begin
        len  <= '0;
        ptr  <= '0;
        busy <= 1'b0;
      end else begin
        if (do_append) len <= len + 1'b1;
        if (ptr_rst) begin
          ptr  <= '0;
          busy <= 1'b0;
        end else begin
          if (busy) begin
            presc <= tick ? '0 : presc + 1'b1;
            if (tick) cnt <= cnt - 1'b1;
          end
          if (fire) begin
            close_pulse <= 1'b1;
            close_chan  <= cur[CH_W-1:0];
            busy        <= chain;
            if (is_last && cont_en) ptr <= '0;
            else                    ptr <= ptr + 1'b1;
            if (is_last && !cont_en) scan_irq <= cur[CH_W];
          end
          if (trig_ok || chain) begin
            busy  <= 1'b1;
            presc <= '0;
            cnt   <= CW'(1) << dly_n;
          end
        end
      end
    end
  end

  a_r4_clear_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_on |=> (len == '0));

  a_r4_no_close_while_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_on && $past(clr_on)) |-> !close_pulse);

  a_r8_irq_with_close: assert property (@(posedge clk) disable iff (!rst_n)
    scan_irq |-> close_pulse);

  a_r3_ptr_within_len: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr <= len) && (len <= LW'(DEPTH)));

  a_r6_delay_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fire && !clr_on && !ptr_rst) |=> (busy && $stable(ptr)));

  a_r5_close_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
    close_pulse |-> $past(busy));
endmodule

// File: tb/test_scan_sequencer.sv
module test_scan_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 3_000_000;
  localparam int DIV        = 3;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       reg_we = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       list_we = 1'b0, list_valid = 1'b0;
  logic [3:0] list_chan = '0;
  logic       trig_in = 1'b0, dbus_trig = 1'b0;
  logic       close_pulse, scan_irq;
  logic [3:0] close_chan;

  scan_sequencer #(.CLK_HZ(CLK_HZ)) i_scan_sequencer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .list_we(list_we),
    .list_valid(list_valid), .list_chan(list_chan), .trig_in(trig_in),
    .dbus_trig(dbus_trig), .close_pulse(close_pulse), .close_chan(close_chan),
    .scan_irq(scan_irq));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0, checks = 0, errors = 0, t_last = 0;
  int    q_cyc[$];
  int    q_ch[$];
  bit    q_irq[$];
  string q_req[$];
  string cur_req = "R5";
  bit    prev_close = 1'b0;

  always @(posedge clk) cyc++;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(bit a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(bit a, logic [7:0] exp, string req);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, "register read", reg_rdata, exp);
  endtask

  task automatic app(bit v, logic [3:0] ch);
    list_valid = v; list_chan = ch; list_we = 1'b1;
    @(negedge clk);
    list_we = 1'b0;
  endtask

  task automatic pulse_trig(bit bus);
    t_last = cyc;
    if (bus) dbus_trig = 1'b1; else trig_in = 1'b1;
    @(negedge clk);
    dbus_trig = 1'b0; trig_in = 1'b0;
  endtask

  function automatic int dcyc(int n);
    return (1 << n) * DIV;
  endfunction

  task automatic expect_close(int offs, logic [3:0] ch, bit irq, string req);
    q_cyc.push_back(t_last + 1 + offs);
    q_ch.push_back(int'(ch));
    q_irq.push_back(irq);
    q_req.push_back(req);
  endtask

  task automatic drain(int n, string req);
    repeat (n) @(negedge clk);
    check(q_cyc.size() == 0, req, "closes still pending", q_cyc.size(), 0);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (close_pulse && prev_close) check(1'b0, "R5", "pulse longer than one cycle", 2, 1);
    if (scan_irq && !close_pulse) check(1'b0, "R8", "irq without close", 1, 0);
    if (close_pulse) begin
      if (q_cyc.size() == 0) begin
        check(1'b0, cur_req, "unexpected close channel", close_chan, 0);
      end else begin
        automatic int    ec = q_cyc.pop_front();
        automatic int    ech = q_ch.pop_front();
        automatic bit    ei = q_irq.pop_front();
        automatic string rq = q_req.pop_front();
        check(cyc == ec, rq, "close cycle", cyc, ec);
        check(close_chan == ech[3:0], rq, "close channel", close_chan, ech);
        check(scan_irq == ei, rq, "irq with close", scan_irq, ei);
      end
    end
    prev_close = close_pulse;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(close_pulse == 1'b0 && scan_irq == 1'b0, "R12", "outputs idle", close_pulse, 0);
    rd_check(1'b0, 8'hF0, "R12");
    rd_check(1'b1, 8'hF0, "R12");

    // R2 delay register, R1 control register
    wr(1'b1, 8'h5A); rd_check(1'b1, 8'hFA, "R2");
    wr(1'b0, 8'hEA); rd_check(1'b0, 8'hFA, "R1");
    wr(1'b0, 8'h16); rd_check(1'b0, 8'hF6, "R1");
    wr(1'b0, 8'h00); rd_check(1'b0, 8'hF0, "R1");

    // R5 / R6 / R8 basic walk, n=1
    wr(1'b1, 8'h01);
    app(1'b1, 4'd5); app(1'b0, 4'd9); app(1'b1, 4'd12);
    cur_req = "R6";
    pulse_trig(1'b0); expect_close(dcyc(1), 4'd5, 1'b0, "R5");
    repeat (2) @(negedge clk);
    pulse_trig(1'b0);
    drain(dcyc(1) + 4, "R6");
    pulse_trig(1'b0); expect_close(dcyc(1), 4'd9, 1'b0, "R5");
    drain(dcyc(1) + 4, "R5");
    pulse_trig(1'b0); expect_close(dcyc(1), 4'd12, 1'b1, "R8");
    drain(dcyc(1) + 4, "R8");
    cur_req = "R8";
    pulse_trig(1'b0);
    drain(dcyc(1) + 6, "R8");

    // R11 pointer reset
    wr(1'b0, 8'h10);
    pulse_trig(1'b0); expect_close(dcyc(1), 4'd5, 1'b0, "R11");
    drain(dcyc(1) + 4, "R11");

    // R4 clear
    cur_req = "R4";
    wr(1'b0, 8'h01);
    app(1'b1, 4'd7);
    pulse_trig(1'b0);
    wr(1'b0, 8'h00);
    pulse_trig(1'b0);
    drain(dcyc(1) + 6, "R4");
    app(1'b1, 4'd7); app(1'b0, 4'd2);
    pulse_trig(1'b0); expect_close(dcyc(1), 4'd7, 1'b0, "R4");
    drain(dcyc(1) + 4, "R4");
    pulse_trig(1'b0); expect_close(dcyc(1), 4'd2, 1'b0, "R8");
    drain(dcyc(1) + 4, "R8");

    // R7 bus trigger gating
    cur_req = "R7";
    wr(1'b0, 8'h10);
    pulse_trig(1'b1);
    drain(dcyc(1) + 6, "R7");
    wr(1'b0, 8'h02);
    pulse_trig(1'b1); expect_close(dcyc(1), 4'd7, 1'b0, "R7");
    drain(dcyc(1) + 4, "R7");

    // R9 continuous wrap
    cur_req = "R9";
    wr(1'b0, 8'h18);
    pulse_trig(1'b0); expect_close(dcyc(1), 4'd7, 1'b0, "R9");
    drain(dcyc(1) + 4, "R9");
    pulse_trig(1'b0); expect_close(dcyc(1), 4'd2, 1'b0, "R9");
    drain(dcyc(1) + 4, "R9");
    pulse_trig(1'b0); expect_close(dcyc(1), 4'd7, 1'b0, "R9");
    drain(dcyc(1) + 4, "R9");

    // R10 immediate run-through, n=0
    cur_req = "R10";
    wr(1'b0, 8'h01); wr(1'b0, 8'h04); wr(1'b1, 8'h00);
    app(1'b0, 4'd1); app(1'b1, 4'd2); app(1'b0, 4'd3); app(1'b1, 4'd4);
    pulse_trig(1'b0);
    for (int i = 1; i <= 4; i++) expect_close(i * dcyc(0), 4'(i), i == 4, "R10");
    drain(5 * dcyc(0) + 4, "R10");

    // R11 cancel a running delay, n=2
    cur_req = "R11";
    wr(1'b0, 8'h10); wr(1'b1, 8'h02);
    pulse_trig(1'b0);
    repeat (3) @(negedge clk);
    wr(1'b0, 8'h10);
    drain(dcyc(2) + 6, "R11");
    pulse_trig(1'b0); expect_close(dcyc(2), 4'd1, 1'b0, "R11");
    drain(dcyc(2) + 4, "R11");

    // R3 full list, extra append dropped
    cur_req = "R3";
    wr(1'b0, 8'h01); wr(1'b0, 8'h04); wr(1'b1, 8'h00);
    for (int i = 0; i < 17; i++) app(i < 16, i < 16 ? 4'(i) : 4'd0);
    pulse_trig(1'b0);
    for (int i = 0; i < 16; i++) expect_close((i + 1) * dcyc(0), 4'(i), i == 15, "R3");
    drain(17 * dcyc(0) + 6, "R3");
    pulse_trig(1'b0);
    drain(dcyc(0) + 6, "R3");

    finish_run();
  end
endmodule